// File: doc/BRIEF.md
# Rotor Lock Protection Timer

This block guards a three-phase brushless drive against a stalled rotor. While the motor is told to run, a cycle counter measures how long the Hall sensor code has stayed unchanged. If no Hall change arrives within a set number of clock cycles, a lock fault latches. The drive uses that fault to keep its high-side switches off. Only a few named events clear the fault. Stop, undervoltage and an explicit initial-reset request act as a full reinitialisation. A direction change or a zero-duty condition releases the fault and restarts the count. Overtemperature only pauses the count.

A second timer watches the PWM input, which is active low: high means the switch is off. When the input stays high for a set number of cycles, the block reports zero duty. That flag releases the lock fault and keeps the count at zero. Together with stop, it also turns off the Hall-sensor bias supply. One low sample on the PWM input removes the zero-duty flag.

All inputs are taken as already synchronous to `clk`. The analog timing capacitor of a discrete design is replaced here by the parameters `LOCK_CYCLES` and `ZERO_CYCLES`.

Top module: `rotor_lock_guard`

## Requirements
- R1: While `rst_n` is low, `lock_fault` and `zero_duty` read 0, and the lock count restarts from zero once reset ends.
- R2: With `stop_req`, `uv_flag`, `ot_flag`, `init_rst` and `zero_duty` all 0, `lock_fault` becomes 1 at the `LOCK_CYCLES`-th rising clock edge after the edge that sampled the last Hall code change. A Hall change sampled at that edge cancels the fault and restarts the count.
- R3: Once `lock_fault` is 1, it stays 1 through any number of Hall code changes until a release event from R4, R5, R7, R8 or R10 occurs.
- R4: `stop_req` = 1 (stop) clears `lock_fault`, the lock count and the zero-duty detector at the next edge and holds them cleared while it stays 1. `hall_bias_en` is 0 in the same cycle that `stop_req` is 1.
- R5: A rising or falling edge on `dir_sel` clears `lock_fault` and the lock count at the next edge.
- R6: `zero_duty` becomes 1 after `pwm_in` has been sampled high (switch off) on `ZERO_CYCLES` consecutive edges. It returns to 0 at the first edge that samples `pwm_in` low.
- R7: While `zero_duty` is 1, `lock_fault` is cleared at the next edge and the lock count is held at zero. `hall_bias_en` is 0 while `zero_duty` is 1.
- R8: `uv_flag` = 1 clears `lock_fault` and the lock count at the next edge, and holds them cleared while it stays 1.
- R9: While `ot_flag` is 1 and no clearing event from R4, R5, R7, R8 or R10 is present, the lock count and `lock_fault` keep their values. Hall changes seen during that time do not restart the count.
- R10: While `init_rst` is 1, `lock_fault` and `zero_duty` are cleared at the next edge and stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_code | input | 3 | Hall sensor code |
| pwm_in | input | 1 | PWM command, low = switch on, high = off |
| stop_req | input | 1 | 1 = stop, 0 = run |
| dir_sel | input | 1 | Rotation direction select |
| uv_flag | input | 1 | Undervoltage detected |
| ot_flag | input | 1 | Overtemperature detected |
| init_rst | input | 1 | Synchronous initial-reset request |
| lock_fault | output | 1 | Latched rotor lock fault; high-side switches must stay off while 1 |
| zero_duty | output | 1 | PWM input held off long enough to count as 0% duty |
| hall_bias_en | output | 1 | Enable for the Hall sensor bias supply |

## Verification
Several pairs of functions can land on the same edge. The most telling pair is lock timeout expiry and a Hall code change. The bench moves the Hall code so that its change is sampled at exactly the edge where the count would expire. It then expects `lock_fault` to stay 0 and a full new timeout to run from that edge. A second coincidence puts the rise of `ot_flag` on the expiry edge. There the count must freeze one step short of the limit, and the fault must appear only on the first edge after `ot_flag` falls.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

  // Per-cycle action for the lock timer, highest priority first.
  typedef enum logic [2:0] {
    EV_INIT    = 3'd0,  // full reinitialisation (stop, undervoltage, init request)
    EV_RELEASE = 3'd1,  // release fault and clear count (direction edge, zero duty)
    EV_FREEZE  = 3'd2,  // hold count and fault (overtemperature)
    EV_RESTART = 3'd3,  // Hall code moved: restart count
    EV_RUN     = 3'd4   // advance count
  } rlg_evt_e;

  localparam int unsigned HALL_W = 3;

endpackage

// File: rtl/rlg_edge_watch.sv
module rlg_edge_watch #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_clr,
  input  logic [W-1:0] code_in,
  input  logic         dir_in,
  output logic         code_chg,
  output logic         dir_chg
);

  logic [W-1:0] code_q, code_d;
  logic         dir_q, dir_d;
  logic         primed_q, primed_d;
  logic [W-1:0] bit_chg;

  // Per-bit difference against the previous sample.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_chg[i] = code_in[i] ^ code_q[i];
  end

  // Edges are reported only once a valid previous sample exists.
  assign code_chg = primed_q & (|bit_chg);
  assign dir_chg  = primed_q & (dir_in ^ dir_q);

  always_comb begin
    code_d   = code_in;
    dir_d    = dir_in;
    primed_d = ~hold_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      dir_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      code_q   <= code_d;
      dir_q    <= dir_d;
      primed_q <= primed_d;
    end
  end

  p_primed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> !code_chg && !dir_chg);

endmodule

// File: rtl/rlg_idle_detect.sv
module rlg_idle_detect #(
  parameter int unsigned ZERO_CYCLES = 150_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pwm_in,
  output logic zero_duty
);

  localparam int unsigned IW = (ZERO_CYCLES > 1) ? $clog2(ZERO_CYCLES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ZERO_CYCLES - 1);

  logic [IW-1:0] cnt_q, cnt_d;
  logic          zero_q, zero_d;
  logic          cnt_en;

  // Count only while the input is off and zero duty is not yet declared.
  assign cnt_en = pwm_in & ~zero_q;

  always_comb begin
    cnt_d  = cnt_q;
    zero_d = zero_q;
    if (clr || !pwm_in) begin
      cnt_d  = '0;
      zero_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        zero_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      zero_q <= zero_d;
    end
  end

  assign zero_duty = zero_q;

  p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |=> !zero_q);

  p_rise_needs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_q) |-> $past(pwm_in) && !$past(clr));

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !zero_q);

endmodule

// File: rtl/rlg_event_arb.sv
module rlg_event_arb
  import rlg_pkg::*;
(
  input  logic     stop_req,
  input  logic     uv_flag,
  input  logic     init_rst,
  input  logic     dir_chg,
  input  logic     zero_duty,
  input  logic     ot_flag,
  input  logic     hall_chg,
  output rlg_evt_e evt
);

  logic full_clr;
  logic release_req;

  assign full_clr    = stop_req | uv_flag | init_rst;
  assign release_req = dir_chg | zero_duty;

  always_comb begin
    if (full_clr) begin
      evt = EV_INIT;
    end else if (release_req) begin
      evt = EV_RELEASE;
    end else if (ot_flag) begin
      evt = EV_FREEZE;
    end else if (hall_chg) begin
      evt = EV_RESTART;
    end else begin
      evt = EV_RUN;
    end
  end

endmodule

// File: rtl/rlg_lock_timer.sv
module rlg_lock_timer
  import rlg_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 100_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rlg_evt_e evt,
  output logic     fault
);

  localparam int unsigned LW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [LW-1:0] LIMIT = LW'(LOCK_CYCLES - 1);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;
  logic          run_en;

  assign run_en = (evt == EV_RUN) & ~fault_q;

  always_comb begin
    cnt_d   = cnt_q;
    fault_d = fault_q;
    unique case (evt)
      EV_INIT, EV_RELEASE: begin
        cnt_d   = '0;
        fault_d = 1'b0;
      end
      EV_FREEZE: begin
        cnt_d   = cnt_q;
        fault_d = fault_q;
      end
      EV_RESTART: begin
        cnt_d = '0;
      end
      default: begin
        if (run_en) begin
          if (cnt_q == LIMIT) begin
            fault_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  p_fault_needs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(evt) == EV_RUN);

  p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && evt != EV_INIT && evt != EV_RELEASE) |=> fault_q);

  p_release_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EV_INIT || evt == EV_RELEASE) |=> !fault_q && cnt_q == '0);

  p_freeze_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt == EV_FREEZE |=> $stable(cnt_q) && $stable(fault_q));

endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard
  import rlg_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 100_000_000,
  parameter int unsigned ZERO_CYCLES = 150_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALL_W-1:0] hall_code,
  input  logic              pwm_in,
  input  logic              stop_req,
  input  logic              dir_sel,
  input  logic              uv_flag,
  input  logic              ot_flag,
  input  logic              init_rst,
  output logic              lock_fault,
  output logic              zero_duty,
  output logic              hall_bias_en
);

  logic     full_clr;
  logic     hall_chg;
  logic     dir_chg;
  logic     zero_flag;
  rlg_evt_e evt;

  assign full_clr = stop_req | uv_flag | init_rst;

  rlg_edge_watch #(
    .W (HALL_W)
  ) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_clr (init_rst),
    .code_in  (hall_code),
    .dir_in   (dir_sel),
    .code_chg (hall_chg),
    .dir_chg  (dir_chg)
  );

  rlg_idle_detect #(
    .ZERO_CYCLES (ZERO_CYCLES)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (full_clr),
    .pwm_in    (pwm_in),
    .zero_duty (zero_flag)
  );

  rlg_event_arb u_arb (
    .stop_req  (stop_req),
    .uv_flag   (uv_flag),
    .init_rst  (init_rst),
    .dir_chg   (dir_chg),
    .zero_duty (zero_flag),
    .ot_flag   (ot_flag),
    .hall_chg  (hall_chg),
    .evt       (evt)
  );

  rlg_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .fault (lock_fault)
  );

  assign zero_duty    = zero_flag;
  assign hall_bias_en = ~stop_req & ~zero_flag;

  p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !lock_fault && !zero_duty);

  p_uv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !lock_fault);

  p_zero_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_duty |=> !lock_fault);

endmodule

// File: tb/rotor_lock_guard_tb.sv
module rotor_lock_guard_tb;

  localparam int LOCK = 24;
  localparam int ZERO = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0] hall_code;
  logic       pwm_in, stop_req, dir_sel, uv_flag, ot_flag, init_rst;
  logic       lock_fault, zero_duty, hall_bias_en;

  int checks;
  int failures;
  bit done;

  rotor_lock_guard #(
    .LOCK_CYCLES (LOCK),
    .ZERO_CYCLES (ZERO)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hall_code    (hall_code),
    .pwm_in       (pwm_in),
    .stop_req     (stop_req),
    .dir_sel      (dir_sel),
    .uv_flag      (uv_flag),
    .ot_flag      (ot_flag),
    .init_rst     (init_rst),
    .lock_fault   (lock_fault),
    .zero_duty    (zero_duty),
    .hall_bias_en (hall_bias_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Six-state Gray rotation of the Hall code.
  task automatic hall_step();
    hall_code = {hall_code[1:0], ~hall_code[2]};
  endtask

  task automatic dir_flip();
    dir_sel = ~dir_sel;
    tick(1);
    dir_sel = dir_sel;
  endtask

  task automatic make_fault(input string req);
    hall_step();
    tick(LOCK + 1);
    chk(req, lock_fault, 1'b1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; hall_code = 3'b001; pwm_in = 1'b0; stop_req = 1'b0;
    dir_sel = 1'b0; uv_flag = 1'b0; ot_flag = 1'b0; init_rst = 1'b0;
    tick(3);
    chk("R1 fault in reset", lock_fault, 1'b0);
    chk("R1 zero in reset", zero_duty, 1'b0);
    chk("R1 bias in reset", hall_bias_en, 1'b1);
    rst_n = 1'b1;

    // R2 sweep over the gap between Hall changes; R5 release after each.
    for (int g = 1; g <= LOCK + 4; g++) begin
      hall_step();
      tick(g);
      chk("R2 timeout sweep", lock_fault, (g >= LOCK + 1));
      dir_flip();
      chk("R5 direction edge release", lock_fault, 1'b0);
    end

    // R2 coincidence: Hall change sampled on the expiry edge.
    hall_step();
    tick(LOCK);
    hall_step();
    tick(1);
    chk("R2 change on expiry edge", lock_fault, 1'b0);
    tick(LOCK - 1);
    chk("R2 restarted count short", lock_fault, 1'b0);
    tick(1);
    chk("R2 restarted count expiry", lock_fault, 1'b1);

    // R3 fault stays latched through Hall activity.
    for (int k = 0; k < 6; k++) begin
      hall_step();
      tick(2);
    end
    chk("R3 latched through hall", lock_fault, 1'b1);
    dir_flip();
    chk("R5 release", lock_fault, 1'b0);

    // R9 freeze mid-count, Hall change during freeze ignored.
    hall_step();
    tick(5);
    ot_flag = 1'b1;
    tick(10);
    hall_step();
    tick(10);
    chk("R9 frozen no fault", lock_fault, 1'b0);
    ot_flag = 1'b0;
    tick(LOCK - 5);
    chk("R9 resume short", lock_fault, 1'b0);
    tick(1);
    chk("R9 resume expiry", lock_fault, 1'b1);
    ot_flag = 1'b1;
    tick(4);
    chk("R9 fault held in freeze", lock_fault, 1'b1);
    ot_flag = 1'b0;
    dir_flip();

    // R9 coincidence: overtemperature rises on the expiry edge.
    hall_step();
    tick(LOCK);
    ot_flag = 1'b1;
    tick(1);
    chk("R9 freeze on expiry edge", lock_fault, 1'b0);
    tick(8);
    chk("R9 still frozen", lock_fault, 1'b0);
    ot_flag = 1'b0;
    tick(1);
    chk("R9 expiry after freeze", lock_fault, 1'b1);
    dir_flip();

    // R6 zero-duty sweep; R7 bias follows.
    for (int p = 1; p <= ZERO + 3; p++) begin
      hall_step();
      pwm_in = 1'b1;
      tick(p);
      chk("R6 zero duty sweep", zero_duty, (p >= ZERO));
      chk("R7 bias vs zero duty", hall_bias_en, !(p >= ZERO));
      pwm_in = 1'b0;
      tick(1);
      chk("R6 low clears", zero_duty, 1'b0);
    end

    // R7 zero duty releases fault and holds count.
    make_fault("R7 setup");
    pwm_in = 1'b1;
    tick(ZERO);
    chk("R7 zero set", zero_duty, 1'b1);
    tick(1);
    chk("R7 fault released", lock_fault, 1'b0);
    tick(LOCK + 5);
    chk("R7 count held", lock_fault, 1'b0);
    pwm_in = 1'b0;
    tick(1);

    // R4 stop.
    make_fault("R4 setup");
    stop_req = 1'b1;
    #1;
    chk("R4 bias off", hall_bias_en, 1'b0);
    tick(1);
    chk("R4 fault cleared", lock_fault, 1'b0);
    pwm_in = 1'b1;
    tick(LOCK + 5);
    chk("R4 held in stop", lock_fault, 1'b0);
    chk("R4 zero held clear", zero_duty, 1'b0);
    pwm_in = 1'b0;
    stop_req = 1'b0;
    tick(1);
    chk("R4 bias back", hall_bias_en, 1'b1);

    // R8 undervoltage.
    make_fault("R8 setup");
    uv_flag = 1'b1;
    tick(1);
    chk("R8 fault cleared", lock_fault, 1'b0);
    tick(LOCK + 5);
    chk("R8 held", lock_fault, 1'b0);
    uv_flag = 1'b0;

    // R10 initial reset request.
    make_fault("R10 setup");
    init_rst = 1'b1;
    pwm_in = 1'b1;
    tick(1);
    chk("R10 fault cleared", lock_fault, 1'b0);
    tick(LOCK + ZERO);
    chk("R10 fault held", lock_fault, 1'b0);
    chk("R10 zero held", zero_duty, 1'b0);
    init_rst = 1'b0;
    pwm_in = 1'b0;
    tick(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule